// File: doc/BRIEF.md
# Register-Operation Executor

This block carries out the register-class instructions of a small accumulator machine. It holds a 16-bit accumulator (AC) and a one-bit extension flag (E). A sequencer decodes the instruction class and raises `exec_en` for one cycle. At the same time it presents the low twelve bits of the instruction word on `op_field`. Each bit of that field selects one operation. In a single cycle the executor can clear or complement AC and E, rotate the 17-bit ring formed by E and AC in either direction, increment AC, test four skip conditions, or stop the machine.

After every accepted operation the executor pulses `seq_reset` for one cycle, so the sequencer returns to its first time step. When a selected skip test holds, the executor pulses `skip_pc` in the same cycle, and the program counter outside the block advances by one extra word. The halt output latches and stays high until reset.

A load port, `load_en`, lets the arithmetic unit write AC and E directly. That path is how the rest of the machine places values in the accumulator.

Top module: `regop_exec`

## Requirements
- R1: While reset is low and in the first cycle after it, the outputs are all zero: AC is 0, E is 0, and `skip_pc`, `halt_q` and `seq_reset` are 0.
- R2: An accepted operation with `op_field[11]` set clears AC. With `op_field[10]` set it clears E.
- R3: An accepted operation with `op_field[9]` set inverts every bit of AC. With `op_field[8]` set it inverts E.
- R4: With `op_field[7]` set, the 17-bit ring rotates right. The new E is the old AC[0], and the new AC is {old E, old AC[15:1]}.
- R5: With `op_field[6]` set, the ring rotates left. The new E is the old AC[15], and the new AC is {old AC[14:0], old E}.
- R6: With `op_field[5]` set, AC becomes AC+1 modulo 2^16, so 0xFFFF wraps to 0x0000. E does not change.
- R7: Four bits select skip tests, all evaluated on the AC and E values from before the operation: `op_field[4]` tests AC[15]==0, `op_field[3]` tests AC[15]==1, `op_field[2]` tests AC==0, and `op_field[1]` tests E==0. If any selected test holds, `skip_pc` is high for exactly the one cycle that follows the accepted operation.
- R8: With `op_field[0]` set, `halt_q` rises in the cycle that follows and stays high until reset. While `halt_q` is high, `exec_en` is ignored: AC and E keep their values, and neither `skip_pc` nor `seq_reset` pulses.
- R9: `seq_reset` is high for exactly the one cycle that follows each accepted operation. It is low in every other cycle.
- R10: When several operation bits are set together, the effects apply in this order: clear, then complement, then rotate right, then rotate left, then increment. Each stage takes the result of the one before it.
- R11: When `load_en` is high and `exec_en` is low, AC and E take the values on `load_ac` and `load_e`. When both are high, `load_en` is ignored.
- R12: When neither `exec_en` nor `load_en` is high, AC, E and `halt_q` keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| exec_en | input | 1 | A register-class instruction is present this cycle |
| op_field | input | 12 | Instruction bits 11..0, one bit for each operation |
| load_en | input | 1 | Write the arithmetic unit's result into AC and E |
| load_ac | input | 16 | Value written to AC by a load |
| load_e | input | 1 | Value written to E by a load |
| ac_q | output | 16 | Accumulator |
| e_q | output | 1 | Extension flag |
| skip_pc | output | 1 | One-cycle request to advance the program counter |
| halt_q | output | 1 | Sticky halt |
| seq_reset | output | 1 | One-cycle request that the sequencer return to its first step |

## Verification
The bench builds the executor with the default 16-bit accumulator. The load path places AC directly at 0xFFFF, 0x8000, 0x0001 and 0x0000, so the wrap of the increment, both sign tests, the zero test and the carry through E in each rotation direction are reached without long count sequences. Random cycles then mix single-bit and multi-bit fields with loads, which exercises the order in which stacked operations apply. The run ends with a halt, attempts to execute while halted, and a second reset.

// File: rtl/regop_pkg.sv
package regop_pkg;
   localparam int OPF_W = 12;

   // Bit position of each operation within op_field
   localparam int B_CLR_AC = 11;
   localparam int B_CLR_E  = 10;
   localparam int B_CMP_AC = 9;
   localparam int B_CMP_E  = 8;
   localparam int B_ROR    = 7;
   localparam int B_ROL    = 6;
   localparam int B_INC    = 5;
   localparam int B_SK_POS = 4;
   localparam int B_SK_NEG = 3;
   localparam int B_SK_ZAC = 2;
   localparam int B_SK_ZE  = 1;
   localparam int B_HALT   = 0;

   typedef struct packed {
      logic clr_ac;
      logic clr_e;
      logic cmp_ac;
      logic cmp_e;
      logic ror;
      logic rol;
      logic inc;
      logic sk_pos;
      logic sk_neg;
      logic sk_zac;
      logic sk_ze;
      logic halt;
   } op_sel_t;
endpackage

// File: rtl/regop_decode.sv
module regop_decode
   import regop_pkg::*;
(
   input  logic [OPF_W-1:0] field,
   output op_sel_t          sel
);
   always_comb begin
      sel.clr_ac = field[B_CLR_AC];
      sel.clr_e  = field[B_CLR_E];
      sel.cmp_ac = field[B_CMP_AC];
      sel.cmp_e  = field[B_CMP_E];
      sel.ror    = field[B_ROR];
      sel.rol    = field[B_ROL];
      sel.inc    = field[B_INC];
      sel.sk_pos = field[B_SK_POS];
      sel.sk_neg = field[B_SK_NEG];
      sel.sk_zac = field[B_SK_ZAC];
      sel.sk_ze  = field[B_SK_ZE];
      sel.halt   = field[B_HALT];
   end
endmodule

// File: rtl/regop_alu.sv
module regop_alu #(
   parameter int DATA_W = 16
) (
   input  logic [DATA_W-1:0] ac_in,
   input  logic              e_in,
   input  logic              clr_ac,
   input  logic              clr_e,
   input  logic              cmp_ac,
   input  logic              cmp_e,
   input  logic              ror,
   input  logic              rol,
   input  logic              inc,
   output logic [DATA_W-1:0] ac_out,
   output logic              e_out
);
   localparam int MSB = DATA_W - 1;

   logic [DATA_W-1:0] ac_s1, ac_s2, ac_s3, ac_rr, ac_rl;
   logic              e_s1, e_s2, e_s3;

   // Clear stage, then complement stage
   always_comb begin
      ac_s1 = clr_ac ? '0 : ac_in;
      e_s1  = clr_e ? 1'b0 : e_in;
      ac_s2 = cmp_ac ? ~ac_s1 : ac_s1;
      e_s2  = cmp_e ? ~e_s1 : e_s1;
   end

   // Rotate-right wiring, bit by bit
   for (genvar i = 0; i < DATA_W; i++) begin : g_rr
      if (i == MSB) begin : g_top
         assign ac_rr[i] = e_s2;
      end else begin : g_mid
         assign ac_rr[i] = ac_s2[i+1];
      end
   end

   always_comb begin
      ac_s3 = ror ? ac_rr : ac_s2;
      e_s3  = ror ? ac_s2[0] : e_s2;
   end

   // Rotate-left wiring, bit by bit
   for (genvar i = 0; i < DATA_W; i++) begin : g_rl
      if (i == 0) begin : g_bot
         assign ac_rl[i] = e_s3;
      end else begin : g_mid
         assign ac_rl[i] = ac_s3[i-1];
      end
   end

   always_comb begin
      logic [DATA_W-1:0] ac_s4;
      ac_s4  = rol ? ac_rl : ac_s3;
      e_out  = rol ? ac_s3[MSB] : e_s3;
      ac_out = inc ? ac_s4 + {{(DATA_W-1){1'b0}}, 1'b1} : ac_s4;
   end

   // R4 R5: a lone rotation moves bits around the ring without changing their count
   always_comb begin
      if ((ror ^ rol) && !clr_ac && !clr_e && !cmp_ac && !cmp_e && !inc)
         a_r4_rotate_keeps_ones: assert ($countones({ac_out, e_out}) == $countones({ac_in, e_in}));
   end
endmodule

// File: rtl/regop_skip.sv
module regop_skip #(
   parameter int DATA_W = 16
) (
   input  logic [DATA_W-1:0] ac_in,
   input  logic              e_in,
   input  logic              sk_pos,
   input  logic              sk_neg,
   input  logic              sk_zac,
   input  logic              sk_ze,
   output logic              hit
);
   logic sign, zero;

   always_comb begin
      sign = ac_in[DATA_W-1];
      zero = ~|ac_in;
      hit  = (sk_pos & ~sign) | (sk_neg & sign) | (sk_zac & zero) | (sk_ze & ~e_in);
   end

   // R7: the two sign tests together always hold
   always_comb begin
      if (sk_pos && sk_neg)
         a_r7_sign_pair_hits: assert (hit);
   end
endmodule

// File: rtl/regop_exec.sv
module regop_exec
   import regop_pkg::*;
#(
   parameter int DATA_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              exec_en,
   input  logic [11:0]       op_field,
   input  logic              load_en,
   input  logic [DATA_W-1:0] load_ac,
   input  logic              load_e,
   output logic [DATA_W-1:0] ac_q,
   output logic              e_q,
   output logic              skip_pc,
   output logic              halt_q,
   output logic              seq_reset
);
   if (DATA_W < 2) begin : g_bad_width
      $error("regop_exec: DATA_W must be at least 2");
   end

   op_sel_t           sel;
   logic [DATA_W-1:0] alu_ac;
   logic              alu_e;
   logic              skip_hit;
   logic              accept;

   regop_decode u_dec (
      .field (op_field),
      .sel   (sel)
   );

   regop_alu #(.DATA_W(DATA_W)) u_alu (
      .ac_in  (ac_q),
      .e_in   (e_q),
      .clr_ac (sel.clr_ac),
      .clr_e  (sel.clr_e),
      .cmp_ac (sel.cmp_ac),
      .cmp_e  (sel.cmp_e),
      .ror    (sel.ror),
      .rol    (sel.rol),
      .inc    (sel.inc),
      .ac_out (alu_ac),
      .e_out  (alu_e)
   );

   regop_skip #(.DATA_W(DATA_W)) u_skip (
      .ac_in  (ac_q),
      .e_in   (e_q),
      .sk_pos (sel.sk_pos),
      .sk_neg (sel.sk_neg),
      .sk_zac (sel.sk_zac),
      .sk_ze  (sel.sk_ze),
      .hit    (skip_hit)
   );

   assign accept = exec_en & ~halt_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ac_q      <= '0;
         e_q       <= 1'b0;
         skip_pc   <= 1'b0;
         halt_q    <= 1'b0;
         seq_reset <= 1'b0;
      end else if (accept) begin
         ac_q      <= alu_ac;
         e_q       <= alu_e;
         skip_pc   <= skip_hit;
         seq_reset <= 1'b1;
         if (sel.halt) halt_q <= 1'b1;
      end else begin
         skip_pc   <= 1'b0;
         seq_reset <= 1'b0;
         if (load_en && !exec_en) begin
            ac_q <= load_ac;
            e_q  <= load_e;
         end
      end
   end

   a_r8_halt_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      halt_q |=> halt_q);

   a_r8_halted_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (halt_q && !(load_en && !exec_en)) |=> ($stable(ac_q) && $stable(e_q) && !seq_reset));

   a_r9_done_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
      (exec_en && !halt_q) |=> seq_reset);

   a_r9_done_single: assert property (@(posedge clk) disable iff (!rst_n)
      !exec_en |=> !seq_reset);

   a_r7_skip_with_done: assert property (@(posedge clk) disable iff (!rst_n)
      skip_pc |-> seq_reset);

   a_r2_clear_ac: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && op_field[11] && op_field[9:5] == 5'b0) |=> (ac_q == '0));

   a_r6_increment: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && op_field[11:5] == 7'b0000001) |=> (ac_q == $past(ac_q) + 1'b1 && e_q == $past(e_q)));

   a_r12_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (!exec_en && !load_en) |=> ($stable(ac_q) && $stable(e_q) && !skip_pc));
endmodule

// File: tb/regop_exec_tb_top.sv
`timescale 1ns/1ps
module regop_exec_tb_top;
   logic        clk = 1'b0;
   logic        rst_n;
   logic        exec_en;
   logic [11:0] op_field;
   logic        load_en;
   logic [15:0] load_ac;
   logic        load_e;
   logic [15:0] ac_q;
   logic        e_q, skip_pc, halt_q, seq_reset;

   int checks = 0;
   int errors = 0;

   // Reference state
   logic [15:0] m_ac;
   logic        m_e, m_skip, m_halt, m_done;

   always #4 clk = ~clk;

   regop_exec #(.DATA_W(16)) dut_i (
      .clk(clk), .rst_n(rst_n), .exec_en(exec_en), .op_field(op_field),
      .load_en(load_en), .load_ac(load_ac), .load_e(load_e),
      .ac_q(ac_q), .e_q(e_q), .skip_pc(skip_pc), .halt_q(halt_q), .seq_reset(seq_reset)
   );

   task automatic check(input string req, input string what, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   function automatic string tag_of(input logic ex, input logic [11:0] f, input logic ld);
      if (ex && m_halt) return "R8";
      if (ex) begin
         if ($countones(f[11:5]) > 1) return "R10";
         if (f[11] || f[10]) return "R2";
         if (f[9] || f[8]) return "R3";
         if (f[7]) return "R4";
         if (f[6]) return "R5";
         if (f[5]) return "R6";
         if (f[0]) return "R8";
         return "R7";
      end
      if (ld) return "R11";
      return "R12";
   endfunction

   // Advance the reference model by one clock
   task automatic model(input logic ex, input logic [11:0] f, input logic ld,
                        input logic [15:0] lac, input logic le);
      logic [15:0] a;
      logic        e, t;
      m_skip = 1'b0;
      m_done = 1'b0;
      if (ex && !m_halt) begin
         a = m_ac; e = m_e;
         if (f[11]) a = 16'h0000;
         if (f[10]) e = 1'b0;
         if (f[9])  a = ~a;
         if (f[8])  e = ~e;
         if (f[7]) begin t = a[0];  a = a >> 1; a[15] = e; e = t; end
         if (f[6]) begin t = a[15]; a = a << 1; a[0] = e;  e = t; end
         if (f[5])  a = a + 16'd1;
         m_skip = (f[4] && m_ac[15] == 1'b0) || (f[3] && m_ac[15] == 1'b1) ||
                  (f[2] && m_ac == 16'h0000) || (f[1] && m_e == 1'b0);
         if (f[0]) m_halt = 1'b1;
         m_done = 1'b1;
         m_ac = a; m_e = e;
      end else if (ld && !ex) begin
         m_ac = lac; m_e = le;
      end
   endtask

   task automatic step(input logic ex, input logic [11:0] f, input logic ld,
                       input logic [15:0] lac, input logic le);
      string tg;
      tg = tag_of(ex, f, ld);
      exec_en = ex; op_field = f; load_en = ld; load_ac = lac; load_e = le;
      model(ex, f, ld, lac, le);
      @(posedge clk);
      @(negedge clk);
      check(tg, "ac", ac_q, m_ac);
      check(tg, "e", e_q, m_e);
      check(ex ? "R7" : "R12", "skip", skip_pc, m_skip);
      check("R8", "halt", halt_q, m_halt);
      check("R9", "seq_reset", seq_reset, m_done);
      exec_en = 0; load_en = 0;
   endtask

   task automatic do_reset();
      rst_n = 0; exec_en = 0; load_en = 0; op_field = '0; load_ac = '0; load_e = 0;
      repeat (2) @(negedge clk);
      rst_n = 1;
      m_ac = '0; m_e = 0; m_skip = 0; m_halt = 0; m_done = 0;
      @(negedge clk);
      check("R1", "ac", ac_q, 0);
      check("R1", "e", e_q, 0);
      check("R1", "skip", skip_pc, 0);
      check("R1", "halt", halt_q, 0);
      check("R1", "seq_reset", seq_reset, 0);
   endtask

   task automatic ld(input logic [15:0] v, input logic e);
      step(0, 12'h000, 1, v, e);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      logic [11:0] f;
      @(negedge clk);
      do_reset();
      // R11 load, R2 clears
      ld(16'hA5A5, 1);
      step(1, 12'h800, 0, 0, 0);
      step(1, 12'h400, 0, 0, 0);
      // R3 complements
      step(1, 12'h200, 0, 0, 0);
      step(1, 12'h100, 0, 0, 0);
      // R4 and R5 through E
      ld(16'h0001, 0);
      step(1, 12'h080, 0, 0, 0);
      step(1, 12'h080, 0, 0, 0);
      ld(16'h8000, 0);
      step(1, 12'h040, 0, 0, 0);
      step(1, 12'h040, 0, 0, 0);
      // R6 wrap
      ld(16'hFFFF, 1);
      step(1, 12'h020, 0, 0, 0);
      step(1, 12'h020, 0, 0, 0);
      // R7 skip tests on both outcomes
      ld(16'h0000, 0);
      step(1, 12'h010, 0, 0, 0);
      step(1, 12'h008, 0, 0, 0);
      step(1, 12'h004, 0, 0, 0);
      step(1, 12'h002, 0, 0, 0);
      ld(16'h8001, 1);
      step(1, 12'h010, 0, 0, 0);
      step(1, 12'h008, 0, 0, 0);
      step(1, 12'h004, 0, 0, 0);
      step(1, 12'h002, 0, 0, 0);
      // R10 stacked; R11 ignored when both asserted
      step(1, 12'hA20, 0, 0, 0);
      step(1, 12'h3C0, 1, 16'h1234, 1);
      step(1, 12'h625, 0, 0, 0);
      // R12 idle
      repeat (3) step(0, 12'hFFF, 0, 16'hBEEF, 1);
      // Random mix
      for (int i = 0; i < 400; i++) begin
         int r;
         r = $urandom_range(0, 9);
         f = 12'h002 << $urandom_range(0, 10);
         if (r < 2) f = 12'($urandom) & 12'hFFE;
         if (r == 9) ld(16'($urandom), 1'($urandom));
         else step(r != 8, f, r == 7, 16'($urandom), 1'($urandom));
      end
      // R8 halt, then ignored execs, load still works
      step(1, 12'h001, 0, 0, 0);
      step(1, 12'h800, 0, 0, 0);
      step(1, 12'h020, 0, 0, 0);
      ld(16'h4321, 1);
      step(1, 12'h200, 0, 0, 0);
      step(0, 12'h000, 0, 0, 0);
      do_reset();
      step(1, 12'h020, 0, 0, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule